// File: doc/BRIEF.md
# Iterative Multiply-Divide Unit with HI/LO Result Pair

This block performs 32-bit integer multiplication and division for a load-store processor core, one bit per clock cycle. A start command carries two register operands and a two-bit operation code that chooses signed or unsigned multiply or divide. No immediate operand form exists. The unit then works for a fixed number of cycles and writes its answer into a dedicated pair of result registers rather than into any general destination.

The pair has a meaning that depends on the operation. After a multiply, the high result register holds the upper half of the 64-bit product and the low one holds the lower half. After a divide, the low register holds the quotient and the high register holds the remainder. The core reaches the pair only through move commands. Move-from requests return either register on a shared read bus. Move-to requests overwrite either register with a supplied value. A read issued while an operation is running raises a stall flag, so the requester waits until the unit is done.

Top module: `muldiv_hilo`

## Requirements
- R1: After reset both result registers read zero, and busy, done and stall are low.
- R2: Operation code 2'b00 (unsigned multiply) leaves the low 32 bits of the unsigned 64-bit product in LO and the high 32 bits in HI. A product that fits in 32 bits leaves HI at zero.
- R3: Operation code 2'b01 (signed multiply) treats both operands as two's complement and leaves the 64-bit two's-complement product split over HI (upper half) and LO (lower half).
- R4: Operation code 2'b10 (unsigned divide) leaves the truncated quotient in LO and the remainder in HI. For example, 10 divided by 3 gives LO = 3 and HI = 1.
- R5: Operation code 2'b11 (signed divide) truncates the quotient toward zero, and the remainder takes the sign of the dividend. The quotient of -2^31 by -1 wraps to 0x80000000 with remainder 0.
- R6: With a zero divisor, either divide variant completes normally with LO = 0xFFFFFFFF and HI = the dividend.
- R7: A start seen while idle raises busy on the next cycle. Busy stays high for exactly 32 cycles. When busy falls, done is high for exactly one cycle, and the new HI/LO values are visible in that same cycle.
- R8: A start raised while busy is ignored: the running operation keeps its operands and its timing.
- R9: While idle, a move-to-HI and/or move-to-LO request writes `wr_data` into the selected register(s) at the next clock edge.
- R10: A move-to request raised while busy has no effect on HI or LO.
- R11: `rd_data` returns HI while `rd_hi` is high and LO otherwise, without delay. `stall` is high exactly when a move-from request is present while busy.
- R12: HI and LO keep their previous contents throughout a running operation until the completing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 32 | First operand (multiplicand or dividend) |
| op_b | input | 32 | Second operand (multiplier or divisor) |
| op_sel | input | 2 | Bit 1: divide; bit 0: signed |
| start | input | 1 | Launch request, accepted only while idle |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_hi | input | 1 | Move-from-HI request |
| rd_lo | input | 1 | Move-from-LO request |
| rd_data | output | 32 | Move-from read data |
| stall | output | 1 | Move-from request held off while busy |
| wr_hi | input | 1 | Move-to-HI request |
| wr_lo | input | 1 | Move-to-LO request |
| wr_data | input | 32 | Value for move-to requests |

## Verification
The hardest conditions to reach from the ports are the ones that occur in the middle of a running operation. These are a second start, a move-to write and a move-from read, each arriving while the shift loop is halfway done. The bench launches an operation and counts falling edges while busy is high. At a chosen count it raises the competing request for a single cycle. It then checks three things: that the read bus still shows the old pair, that the stall flag is raised, and that the final result, the busy length and the done pulse all belong to the first operation. Sign corners such as the most negative dividend over -1, mixed-sign remainders and zero divisors are driven as directed operands, and their expected values are computed in 64-bit arithmetic.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

  // bit 1 selects divide, bit 0 selects signed operands
  typedef enum logic [1:0] {
    OP_MULU = 2'b00,
    OP_MULS = 2'b01,
    OP_DIVU = 2'b10,
    OP_DIVS = 2'b11
  } md_op_e;

endpackage

// File: rtl/md_engine.sv
module md_engine
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  md_op_e       op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         busy,
  output logic         fin,
  output logic [W-1:0] res_hi,
  output logic [W-1:0] res_lo
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  // absolute value when the operand is signed and negative
  function automatic logic [W-1:0] magnitude(input logic [W-1:0] x, input logic sgn);
    return (sgn && x[W-1]) ? -x : x;
  endfunction

  // one shift-add step: {upper, lower} of the growing product
  function automatic logic [2*W-1:0] mul_step(input logic [W-1:0] up,
                                              input logic [W-1:0] lo,
                                              input logic [W-1:0] m);
    logic [W:0] s;
    s = {1'b0, up} + (lo[0] ? {1'b0, m} : '0);
    return {s[W:1], s[0], lo[W-1:1]};
  endfunction

  // one restoring shift-subtract step: {remainder, quotient bits}
  function automatic logic [2*W-1:0] div_step(input logic [W-1:0] up,
                                              input logic [W-1:0] lo,
                                              input logic [W-1:0] m);
    logic [W:0] sh;
    logic [W:0] tr;
    sh = {up, lo[W-1]};
    tr = sh - {1'b0, m};
    return tr[W] ? {sh[W-1:0], lo[W-2:0], 1'b0} : {tr[W-1:0], lo[W-2:0], 1'b1};
  endfunction

  logic          busy_q;
  logic [CW-1:0] cnt_q;
  logic          div_q, negq_q, negr_q, dz_q;
  logic [W-1:0]  dvd_q, up_q, lo_q, m_q;
  logic [2*W-1:0] nxt, prod;
  logic [W-1:0]  quo, rem;
  logic          sa, sb;

  assign sa = op[0] & a[W-1];
  assign sb = op[0] & b[W-1];

  assign nxt  = div_q ? div_step(up_q, lo_q, m_q) : mul_step(up_q, lo_q, m_q);
  assign prod = negq_q ? -nxt : nxt;
  assign quo  = negq_q ? -nxt[W-1:0] : nxt[W-1:0];
  assign rem  = negr_q ? -nxt[2*W-1:W] : nxt[2*W-1:W];

  always_comb begin
    if (!div_q) begin
      res_hi = prod[2*W-1:W];
      res_lo = prod[W-1:0];
    end else if (dz_q) begin
      res_hi = dvd_q;
      res_lo = '1;
    end else begin
      res_hi = rem;
      res_lo = quo;
    end
  end

  assign busy = busy_q;
  assign fin  = busy_q && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      div_q  <= 1'b0;
      negq_q <= 1'b0;
      negr_q <= 1'b0;
      dz_q   <= 1'b0;
      dvd_q  <= '0;
      up_q   <= '0;
      lo_q   <= '0;
      m_q    <= '0;
    end else if (go && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      div_q  <= op[1];
      negq_q <= sa ^ sb;
      negr_q <= sa;
      dz_q   <= (b == '0);
      dvd_q  <= a;
      up_q   <= '0;
      lo_q   <= op[1] ? magnitude(a, op[0]) : magnitude(b, op[0]);
      m_q    <= op[1] ? magnitude(b, op[0]) : magnitude(a, op[0]);
    end else if (busy_q) begin
      up_q  <= nxt[2*W-1:W];
      lo_q  <= nxt[W-1:0];
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) busy_q <= 1'b0;
    end
  end

endmodule

// File: rtl/md_hilo_regs.sv
module md_hilo_regs #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] res_hi,
  input  logic [W-1:0] res_lo,
  input  logic         wr_hi_en,
  input  logic         wr_lo_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi <= '0;
      lo <= '0;
    end else if (load) begin
      hi <= res_hi;
      lo <= res_lo;
    end else begin
      if (wr_hi_en) hi <= wr_data;
      if (wr_lo_en) lo <= wr_data;
    end
  end
endmodule

// File: rtl/muldiv_hilo.sv
module muldiv_hilo
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [1:0]   op_sel,
  input  logic         start,
  output logic         busy,
  output logic         done,
  input  logic         rd_hi,
  input  logic         rd_lo,
  output logic [W-1:0] rd_data,
  output logic         stall,
  input  logic         wr_hi,
  input  logic         wr_lo,
  input  logic [W-1:0] wr_data
);
  logic         accept;
  logic         eng_busy;
  logic         finish;
  logic         done_q;
  logic [W-1:0] res_hi, res_lo;
  logic [W-1:0] hi_q, lo_q;

  assign accept = start & ~eng_busy;

  md_engine #(.W(W)) u_engine (
    .clk    (clk),
    .rst_n  (rst_n),
    .go     (accept),
    .op     (md_op_e'(op_sel)),
    .a      (op_a),
    .b      (op_b),
    .busy   (eng_busy),
    .fin    (finish),
    .res_hi (res_hi),
    .res_lo (res_lo)
  );

  md_hilo_regs #(.W(W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (finish),
    .res_hi   (res_hi),
    .res_lo   (res_lo),
    .wr_hi_en (wr_hi & ~eng_busy),
    .wr_lo_en (wr_lo & ~eng_busy),
    .wr_data  (wr_data),
    .hi       (hi_q),
    .lo       (lo_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= finish;
  end

  assign busy    = eng_busy;
  assign done    = done_q;
  assign rd_data = rd_hi ? hi_q : lo_q;
  assign stall   = eng_busy & (rd_hi | rd_lo);

endmodule

// File: rtl/muldiv_hilo_chk.sv
module muldiv_hilo_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic         stall,
  input logic         rd_hi,
  input logic         rd_lo,
  input logic         wr_hi,
  input logic         wr_lo,
  input logic [W-1:0] wr_data,
  input logic [W-1:0] hi_q,
  input logic [W-1:0] lo_q
);
  localparam int LW = $clog2(W) + 2;
  logic [LW-1:0] blen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              blen <= '0;
    else if (start && !busy) blen <= '0;
    else if (busy)           blen <= blen + 1'b1;
  end

  // R7
  busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7
  done_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  // R7
  busy_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (blen == LW'(W)));
  // R8
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && blen != LW'(W - 1)) |=> busy);
  // R9
  move_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && !busy) |=> (hi_q == $past(wr_data)));
  // R9
  move_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !busy) |=> (lo_q == $past(wr_data)));
  // R11
  stall_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (busy && (rd_hi || rd_lo)));
  // R12
  pair_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(hi_q) && $stable(lo_q)));

endmodule

bind muldiv_hilo muldiv_hilo_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .stall   (stall),
  .rd_hi   (rd_hi),
  .rd_lo   (rd_lo),
  .wr_hi   (wr_hi),
  .wr_lo   (wr_lo),
  .wr_data (wr_data),
  .hi_q    (hi_q),
  .lo_q    (lo_q)
);

// File: tb/muldiv_hilo_test.sv
`timescale 1ns/1ps
module muldiv_hilo_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] op_a = '0, op_b = '0, wr_data = '0;
  logic [1:0]  op_sel = '0;
  logic        start = 1'b0, rd_hi = 1'b0, rd_lo = 1'b0, wr_hi = 1'b0, wr_lo = 1'b0;
  logic        busy, done, stall;
  logic [31:0] rd_data;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  muldiv_hilo uut (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
    .start(start), .busy(busy), .done(done), .rd_hi(rd_hi), .rd_lo(rd_lo),
    .rd_data(rd_data), .stall(stall), .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_data(wr_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected pair from the requirement text, in 64-bit arithmetic
  task automatic expect_pair(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                             output logic [31:0] eh, output logic [31:0] el);
    logic [63:0] p;
    longint sa, sb, q, r;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    case (op)
      2'b00: begin p = {32'b0, a} * {32'b0, b}; eh = p[63:32]; el = p[31:0]; end
      2'b01: begin p = 64'(sa * sb); eh = p[63:32]; el = p[31:0]; end
      default: begin
        if (b == 0) begin eh = a; el = 32'hFFFF_FFFF; end
        else if (op == 2'b10) begin eh = a % b; el = a / b; end
        else begin q = sa / sb; r = sa % sb; eh = r[31:0]; el = q[31:0]; end
      end
    endcase
  endtask

  task automatic read_pair(output logic [31:0] h, output logic [31:0] l);
    rd_hi = 1'b1; #1 h = rd_data; rd_hi = 1'b0;
    rd_lo = 1'b1; #1 l = rd_data; rd_lo = 1'b0;
  endtask

  task automatic launch(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    op_sel = op; op_a = a; op_b = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // counts busy cycles from the first sample after launch; checks R7 timing
  task automatic finish_op(input string req);
    int n;
    n = 0;
    while (busy && n < 100) begin n++; @(negedge clk); end
    chk({req, " R7 busy cycles"}, 32'(n), 32'd32);
    chk({req, " R7 done high"}, {31'b0, done}, 32'd1);
    @(negedge clk);
    chk({req, " R7 done drops"}, {31'b0, done}, 32'd0);
  endtask

  task automatic run_op(input string req, input logic [1:0] op,
                        input logic [31:0] a, input logic [31:0] b);
    logic [31:0] eh, el, h, l;
    expect_pair(op, a, b, eh, el);
    launch(op, a, b);
    finish_op(req);
    read_pair(h, l);
    chk({req, " HI"}, h, eh);
    chk({req, " LO"}, l, el);
  endtask

  task automatic t_reset;
    logic [31:0] h, l;
    @(negedge clk);
    chk("R1 busy", {31'b0, busy}, 0);
    chk("R1 done", {31'b0, done}, 0);
    rd_hi = 1'b1; #1 chk("R1 stall", {31'b0, stall}, 0); rd_hi = 1'b0;
    read_pair(h, l);
    chk("R1 HI", h, 0);
    chk("R1 LO", l, 0);
  endtask

  task automatic t_multiply;
    run_op("R2 small", 2'b00, 32'd1234, 32'd5678);
    run_op("R2 wide", 2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    run_op("R2 zero", 2'b00, 32'h8000_0001, 32'd0);
    run_op("R3 neg*pos", 2'b01, 32'hFFFF_FFF9, 32'd6);
    run_op("R3 neg*neg", 2'b01, 32'h8000_0000, 32'h8000_0000);
    run_op("R3 pos*neg", 2'b01, 32'h1234_5678, 32'hFEDC_BA98);
  endtask

  task automatic t_divide;
    run_op("R4 10/3", 2'b10, 32'd10, 32'd3);
    run_op("R4 big", 2'b10, 32'hFFFF_FFFF, 32'd7);
    run_op("R4 small num", 2'b10, 32'd5, 32'h8000_0000);
    run_op("R5 -7/2", 2'b11, 32'hFFFF_FFF9, 32'd2);
    run_op("R5 7/-2", 2'b11, 32'd7, 32'hFFFF_FFFE);
    run_op("R5 -7/-2", 2'b11, 32'hFFFF_FFF9, 32'hFFFF_FFFE);
    run_op("R5 min/-1", 2'b11, 32'h8000_0000, 32'hFFFF_FFFF);
  endtask

  task automatic t_div_zero;
    run_op("R6 unsigned", 2'b10, 32'd99, 32'd0);
    run_op("R6 signed", 2'b11, 32'hFFFF_FF00, 32'd0);
  endtask

  task automatic t_move_idle;
    logic [31:0] h, l;
    @(negedge clk); wr_hi = 1'b1; wr_data = 32'hA5A5_0001;
    @(negedge clk); wr_hi = 1'b0; wr_lo = 1'b1; wr_data = 32'h5A5A_0002;
    @(negedge clk); wr_lo = 1'b0;
    read_pair(h, l);
    chk("R9 HI write", h, 32'hA5A5_0001);
    chk("R9 LO write", l, 32'h5A5A_0002);
    wr_hi = 1'b1; wr_lo = 1'b1; wr_data = 32'h0BAD_F00D;
    @(negedge clk); wr_hi = 1'b0; wr_lo = 1'b0;
    read_pair(h, l);
    chk("R9 both HI", h, 32'h0BAD_F00D);
    chk("R9 both LO", l, 32'h0BAD_F00D);
  endtask

  task automatic t_busy_access;
    logic [31:0] h, l;
    int n;
    @(negedge clk); wr_hi = 1'b1; wr_lo = 1'b1; wr_data = 32'h0000_1234;
    @(negedge clk); wr_hi = 1'b0; wr_lo = 1'b0;
    launch(2'b00, 32'd7, 32'd6);
    n = 0;
    while (busy && n < 100) begin
      if (n == 3) begin wr_hi = 1'b1; wr_lo = 1'b1; wr_data = 32'hDEAD_BEEF; end
      if (n == 4) begin
        wr_hi = 1'b0; wr_lo = 1'b0;
        rd_hi = 1'b1; #1;
        chk("R12 HI held while busy", rd_data, 32'h0000_1234);
        chk("R11 stall on read", {31'b0, stall}, 32'd1);
        rd_hi = 1'b0; rd_lo = 1'b1; #1;
        chk("R10 LO write ignored", rd_data, 32'h0000_1234);
        rd_lo = 1'b0;
      end
      n++;
      @(negedge clk);
    end
    chk("R7 busy cycles with traffic", 32'(n), 32'd32);
    rd_lo = 1'b1; #1;
    chk("R11 no stall when idle", {31'b0, stall}, 32'd0);
    rd_lo = 1'b0;
    read_pair(h, l);
    chk("R10 HI result", h, 32'd0);
    chk("R10 LO result", l, 32'd42);
  endtask

  task automatic t_start_busy;
    logic [31:0] h, l, eh, el;
    int n;
    expect_pair(2'b10, 32'd1000, 32'd7, eh, el);
    launch(2'b10, 32'd1000, 32'd7);
    n = 0;
    while (busy && n < 100) begin
      if (n == 5) begin op_sel = 2'b00; op_a = 32'd3; op_b = 32'd3; start = 1'b1; end
      if (n == 6) start = 1'b0;
      n++;
      @(negedge clk);
    end
    chk("R8 busy not restarted", 32'(n), 32'd32);
    read_pair(h, l);
    chk("R8 HI first op", h, eh);
    chk("R8 LO first op", l, el);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_multiply();
    t_divide();
    t_div_zero();
    t_move_idle();
    t_busy_access();
    t_start_busy();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule